// File: doc/BRIEF.md
# Memory-Mapped Reconfiguration Control Front End

This block puts a word-addressed memory-mapped slave in front of a partial reconfiguration controller. A master programs the controller through two locations. One is a data port that turns each write into a single beat on a valid/ready stream. The other is a control/status word. It launches an operation, selects a two-pass operation, and returns the controller's 3-bit outcome code.

A typical sequence has three steps. The master first writes 1 to the control word, or 3 to request the two-pass mode. It then writes every bitstream word to the data port. Finally it reads the control word until the outcome code changes. While the stream sink cannot take a word, the slave holds off the master with wait-request. Reads always take one wait state, so the returned word comes from a register.

Top module: `prcfg_mm_bridge`

## Requirements
- R1: While reset is high, and after it until the first access, ctl_start and ctl_double are 0, st_valid is 0 and mm_waitreq is 0.
- R2: A write with mm_addr=0 drives mm_wdata onto st_data with st_valid high. At all other times st_valid is low.
- R3: A write with mm_addr=1 and mm_wdata bit 0 set makes ctl_start high for exactly the one following cycle. The bit then returns to 0 with no further write.
- R4: During a write with mm_addr=0, mm_waitreq follows the inverse of st_ready. The write completes on the edge where st_ready is high, so each write produces exactly one accepted stream beat.
- R5: ctl_double takes mm_wdata bit 1 of each write with mm_addr=1 and holds it until the next such write.
- R6: A read takes exactly one wait state. mm_waitreq is high in the first cycle of the read and low in the second, and the read data is valid in that second cycle.
- R7: A read with mm_addr=0 returns all zeros.
- R8: A read with mm_addr=1 returns ctl_status in bits 4..2, ctl_double in bit 1, the start bit in bit 0 and zero in all higher bits.
- R9: A write with mm_addr=1 completes with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mm_addr | input | 1 | Word address: 0 = data port, 1 = control/status |
| mm_read | input | 1 | Read request |
| mm_write | input | 1 | Write request |
| mm_wdata | input | DATA_W | Write data |
| mm_rdata | output | DATA_W | Registered read data |
| mm_waitreq | output | 1 | Stall for the current transfer |
| st_data | output | DATA_W | Bitstream word to the controller |
| st_valid | output | 1 | Stream word valid |
| st_ready | input | 1 | Controller can take a word |
| ctl_start | output | 1 | One-cycle launch pulse |
| ctl_double | output | 1 | Two-pass operation select |
| ctl_status | input | 3 | Outcome code from the controller |

## Verification
A stuck or stale control register shows up directly on ctl_start or ctl_double. If the start bit failed to clear, the pulse would last past the cycle after the write and could be seen at once. A wrong stall term in the wait-request logic would either let a data write complete without a stream beat or produce extra beats. The scoreboard catches both, because it counts beats and matches them against the queued words in the cycle they are accepted. A wrong read-path state would change the length of the wait state or corrupt the packed status word, and that is seen on the very next read.

// File: rtl/prmm_pkg.sv
package prmm_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'd0,
        CMD_DATA_WR = 2'd1,
        CMD_CSR_WR  = 2'd2,
        CMD_READ    = 2'd3
    } cmd_e;

    typedef struct packed {
        logic dbl;
        logic start;
    } ctl_reg_t;

    localparam int START_BIT = 0;
    localparam int DBL_BIT   = 1;
    localparam int STAT_LSB  = 2;
    localparam int STAT_W    = 3;
    localparam int WORD_MAX  = 32;

    // Build the control/status read word; reserved bits are zero.
    function automatic logic [WORD_MAX-1:0] pack_ctl(input ctl_reg_t c,
                                                     input logic [STAT_W-1:0] st);
        logic [WORD_MAX-1:0] w;
        w = '0;
        w[START_BIT] = c.start;
        w[DBL_BIT]   = c.dbl;
        w[STAT_LSB +: STAT_W] = st;
        return w;
    endfunction

endpackage

// File: rtl/prmm_decode.sv
module prmm_decode
    import prmm_pkg::*;
(
    input  logic mm_addr,
    input  logic mm_read,
    input  logic mm_write,
    output cmd_e cmd
);
    always_comb begin
        if (mm_write)
            cmd = mm_addr ? CMD_CSR_WR : CMD_DATA_WR;
        else if (mm_read)
            cmd = CMD_READ;
        else
            cmd = CMD_IDLE;
    end
endmodule

// File: rtl/prmm_ctl.sv
module prmm_ctl
    import prmm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [1:0] wr_bits,
    output ctl_reg_t   ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else begin
            // start is a pulse: set only by the write itself, cleared otherwise
            ctl.start <= wr_en & wr_bits[START_BIT];
            if (wr_en)
                ctl.dbl <= wr_bits[DBL_BIT];
        end
    end
endmodule

// File: rtl/prmm_stream.sv
module prmm_stream
    import prmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              st_ready,
    output logic [DATA_W-1:0] st_data,
    output logic              st_valid,
    output logic              stall
);
    logic is_data;

    assign is_data  = (cmd == CMD_DATA_WR);
    assign st_valid = is_data;
    assign st_data  = wdata;
    // The bus transfer ends on the same edge the beat is taken.
    assign stall    = is_data & ~st_ready;
endmodule

// File: rtl/prmm_rdpath.sv
module prmm_rdpath
    import prmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic              addr,
    input  ctl_reg_t          ctl,
    input  logic [STAT_W-1:0] status,
    output logic [DATA_W-1:0] rdata,
    output logic              stall
);
    logic                rd_pend;
    logic                rd_first;
    logic [WORD_MAX-1:0] full_word;
    logic [DATA_W-1:0]   csr_word;

    assign full_word = pack_ctl(ctl, status);
    assign csr_word  = full_word[DATA_W-1:0];
    assign rd_first  = (cmd == CMD_READ) & ~rd_pend;
    assign stall     = rd_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_pend <= 1'b0;
            rdata   <= '0;
        end else begin
            rd_pend <= rd_first;
            if (rd_first)
                rdata <= addr ? csr_word : '0;
        end
    end
endmodule

// File: rtl/prcfg_mm_bridge.sv
module prcfg_mm_bridge
    import prmm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mm_addr,
    input  logic              mm_read,
    input  logic              mm_write,
    input  logic [DATA_W-1:0] mm_wdata,
    output logic [DATA_W-1:0] mm_rdata,
    output logic              mm_waitreq,
    output logic [DATA_W-1:0] st_data,
    output logic              st_valid,
    input  logic              st_ready,
    output logic              ctl_start,
    output logic              ctl_double,
    input  logic [2:0]        ctl_status
);
    generate
        if (DATA_W != 16 && DATA_W != 32) begin : g_bad_width
            $error("prcfg_mm_bridge: DATA_W must be 16 or 32");
        end
    endgenerate

    cmd_e     cmd;
    ctl_reg_t ctl;
    logic     wr_stall;
    logic     rd_stall;

    prmm_decode u_dec (
        .mm_addr (mm_addr),
        .mm_read (mm_read),
        .mm_write(mm_write),
        .cmd     (cmd)
    );

    prmm_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmd == CMD_CSR_WR),
        .wr_bits(mm_wdata[1:0]),
        .ctl    (ctl)
    );

    prmm_stream #(.DATA_W(DATA_W)) u_str (
        .cmd     (cmd),
        .wdata   (mm_wdata),
        .st_ready(st_ready),
        .st_data (st_data),
        .st_valid(st_valid),
        .stall   (wr_stall)
    );

    prmm_rdpath #(.DATA_W(DATA_W)) u_rd (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd),
        .addr  (mm_addr),
        .ctl   (ctl),
        .status(ctl_status),
        .rdata (mm_rdata),
        .stall (rd_stall)
    );

    assign mm_waitreq = wr_stall | rd_stall;
    assign ctl_start  = ctl.start;
    assign ctl_double = ctl.dbl;
endmodule

// File: rtl/prmm_checker.sv
module prmm_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              mm_addr,
    input logic              mm_read,
    input logic              mm_write,
    input logic [DATA_W-1:0] mm_wdata,
    input logic [DATA_W-1:0] mm_rdata,
    input logic              mm_waitreq,
    input logic              st_valid,
    input logic              st_ready,
    input logic              ctl_start,
    input logic              ctl_double
);
    // R2
    a_r2_valid_only_on_data_write: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (mm_write && !mm_addr));

    // R3
    a_r3_start_follows_write: assert property (@(posedge clk) disable iff (rst)
        ctl_start |-> $past(mm_write && mm_addr && mm_wdata[0]));

    // R4
    a_r4_stall_while_not_ready: assert property (@(posedge clk) disable iff (rst)
        (mm_write && !mm_addr && !st_ready) |-> mm_waitreq);

    // R5
    a_r5_double_holds: assert property (@(posedge clk) disable iff (rst)
        !(mm_write && mm_addr) |=> $stable(ctl_double));

    // R6
    a_r6_read_one_wait: assert property (@(posedge clk) disable iff (rst)
        (mm_read && !mm_write && !mm_waitreq) |-> $past(mm_read && mm_waitreq));

    // R7
    a_r7_data_read_zero: assert property (@(posedge clk) disable iff (rst)
        (mm_read && !mm_write && !mm_waitreq && !mm_addr) |-> (mm_rdata == '0));

    // R9
    a_r9_csr_write_no_wait: assert property (@(posedge clk) disable iff (rst)
        (mm_write && mm_addr) |-> !mm_waitreq);
endmodule

bind prcfg_mm_bridge prmm_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mm_addr   (mm_addr),
    .mm_read   (mm_read),
    .mm_write  (mm_write),
    .mm_wdata  (mm_wdata),
    .mm_rdata  (mm_rdata),
    .mm_waitreq(mm_waitreq),
    .st_valid  (st_valid),
    .st_ready  (st_ready),
    .ctl_start (ctl_start),
    .ctl_double(ctl_double)
);

// File: tb/prcfg_mm_bridge_tb_top.sv
module prcfg_mm_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mm_addr = 1'b0;
    logic              mm_read = 1'b0;
    logic              mm_write = 1'b0;
    logic [DATA_W-1:0] mm_wdata = '0;
    logic [DATA_W-1:0] mm_rdata;
    logic              mm_waitreq;
    logic [DATA_W-1:0] st_data;
    logic              st_valid;
    logic              st_ready = 1'b0;
    logic              ctl_start;
    logic              ctl_double;
    logic [2:0]        ctl_status = 3'b000;

    int checks = 0;
    int errors = 0;
    int beats  = 0;
    int pushed = 0;
    logic [DATA_W-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prcfg_mm_bridge #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst(rst), .mm_addr(mm_addr), .mm_read(mm_read),
        .mm_write(mm_write), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata),
        .mm_waitreq(mm_waitreq), .st_data(st_data), .st_valid(st_valid),
        .st_ready(st_ready), .ctl_start(ctl_start), .ctl_double(ctl_double),
        .ctl_status(ctl_status)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: every accepted beat must match the next queued word (R2, R4).
    always @(negedge clk) begin
        if (!rst && st_valid && st_ready) begin
            beats++;
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: actual beat %h expected no beat", st_data);
            end else begin
                check("R2 beat data", st_data, exp_q.pop_front());
            end
        end
    end

    task automatic data_write(input logic [DATA_W-1:0] w, input int stall);
        mm_write = 1'b1; mm_addr = 1'b0; mm_wdata = w;
        st_ready = (stall == 0);
        exp_q.push_back(w);
        pushed++;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R4 stall while not ready", {31'd0, mm_waitreq}, 32'd1);
            check("R2 valid during data write", {31'd0, st_valid}, 32'd1);
            step();
        end
        st_ready = 1'b1;
        @(negedge clk);
        check("R4 no stall when ready", {31'd0, mm_waitreq}, 32'd0);
        step();
        mm_write = 1'b0;
        st_ready = 1'b0;
    endtask

    task automatic csr_write(input logic [1:0] v);
        mm_write = 1'b1; mm_addr = 1'b1; mm_wdata = {30'd0, v};
        @(negedge clk);
        check("R9 csr write no wait", {31'd0, mm_waitreq}, 32'd0);
        step();
        mm_write = 1'b0;
        @(negedge clk);
        check("R3 start pulse", {31'd0, ctl_start}, {31'd0, v[0]});
        check("R5 double value", {31'd0, ctl_double}, {31'd0, v[1]});
        step();
        @(negedge clk);
        check("R3 start self-clear", {31'd0, ctl_start}, 32'd0);
    endtask

    task automatic mm_rd(input logic a, input logic [DATA_W-1:0] exp, input string req);
        mm_read = 1'b1; mm_addr = a;
        @(negedge clk);
        check("R6 first read cycle waits", {31'd0, mm_waitreq}, 32'd1);
        step();
        @(negedge clk);
        check("R6 second read cycle done", {31'd0, mm_waitreq}, 32'd0);
        check(req, mm_rdata, exp);
        step();
        mm_read = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(); step();
        @(negedge clk);
        check("R1 start in reset", {31'd0, ctl_start}, 32'd0);
        check("R1 double in reset", {31'd0, ctl_double}, 32'd0);
        check("R1 valid in reset", {31'd0, st_valid}, 32'd0);
        check("R1 wait in reset", {31'd0, mm_waitreq}, 32'd0);
        step();
        rst = 1'b0;
        st_ready = 1'b1;
        @(negedge clk);
        check("R1 idle wait low", {31'd0, mm_waitreq}, 32'd0);
        check("R2 no valid when idle", {31'd0, st_valid}, 32'd0);
        step();
        st_ready = 1'b0;

        // launch a single-pass operation, then a two-pass one
        csr_write(2'b01);
        step();
        csr_write(2'b11);
        step();
        // double bit holds across data writes (R5)
        ctl_status = 3'b100;
        data_write(32'hDEAD_0001, 0);
        data_write(32'hA5A5_5A5A, 2);
        data_write(32'h0000_FFFF, 5);
        data_write(32'h1234_5678, 1);
        @(negedge clk);
        check("R5 double held", {31'd0, ctl_double}, 32'd1);
        check("R2 valid low after writes", {31'd0, st_valid}, 32'd0);
        step();

        // read-back of both offsets
        mm_rd(1'b0, 32'd0, "R7 data read zero");
        mm_rd(1'b1, 32'h0000_0012, "R8 csr read status 100 dbl 1");
        ctl_status = 3'b011;
        csr_write(2'b00);
        step();
        mm_rd(1'b1, 32'h0000_000C, "R8 csr read status 011 dbl 0");
        ctl_status = 3'b101;
        csr_write(2'b10);
        step();
        mm_rd(1'b1, 32'h0000_0016, "R8 csr read status 101 dbl 1");
        mm_rd(1'b0, 32'd0, "R7 data read zero again");

        step();
        check("R4 one beat per write", beats, pushed);
        check("R4 scoreboard drained", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule